// File: doc/BRIEF.md
# Dual-Port Memory Checkerboard Self-Test Engine

This block wraps a two-port SRAM that has a write-only port and a read-only port, and runs a continuous go/no-go test over it. While `test_en` is low, the user's write and read requests go straight through to the RAM. When `test_en` is high, the engine takes over both ports. It first fills every word with an alternating-bit pattern. It then runs check passes over the memory without end. In each check pass it reads one address per cycle on the read port. In the same cycle it writes the inverted pattern through the write port to the address it read one cycle earlier. A pass therefore overlaps checking with rewriting, and the next pass checks the value the previous pass wrote.

Every address whose returned word differs from the expected word raises `test_fail` for one cycle. Because the engine keeps looping, a slow tester can watch for any pulse during manufacturing test. A fast counter can also tally pulses when bits are flipped in place, for example during an upset study. The RAM model is assumed to have one cycle of read latency: data for an address read in cycle c is present on `ram_rdata` during cycle c+1. The memory ports are plain request ports with no back-pressure. The RAM accepts one read and one write in every cycle, so the block has no valid/ready handshake.

Top module: `dpram_selftest`

## Requirements
- R1: While `test_en` is low, and the engine has been idle since the previous edge, every `ram_*` request output equals the matching `usr_*` input and `test_fail` is low. `usr_rdata` always equals `ram_rdata`.
- R2: On the clock edge after `test_en` is first seen high, a fill pass starts. For DEPTH cycles it writes the base pattern to addresses 0, 1, … DEPTH-1 in ascending order, with `ram_re` low. Bit i of the base pattern is 1 when i is odd, which gives 0x2AA for a 10-bit word.
- R3: A check pass lasts DEPTH+1 cycles. In pass cycle j, for j from 0 to DEPTH-1, the engine reads address j. In pass cycle j, for j from 1 to DEPTH, it writes address j-1. Cycle 0 has no write, and cycle DEPTH has no read.
- R4: Whenever `ram_we` and `ram_re` are both high, `ram_waddr` differs from `ram_raddr`.
- R5: The word written to an address in a check pass is the bitwise inverse of the value that pass expects, whatever value was read back.
- R6: The first check pass after fill expects the base pattern. After that, the expected word alternates between the inverse pattern (0x155) and the base pattern from pass to pass.
- R7: If the word read from an address differs from the expected word, `test_fail` is high for exactly one cycle. That cycle is two cycles after the cycle in which the address was read. Failing reads on consecutive addresses give adjacent high cycles.
- R8: While the engine owns the memory, the `usr_*` request inputs have no effect on the `ram_*` outputs.
- R9: When `test_en` falls, the ports return to the user path on the next edge. A later rise of `test_en` restarts with a fill pass from address 0.
- R10: A word with several wrong bits produces a single one-cycle pulse, the same as a word with one wrong bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_en | input | 1 | High to run the self-test loop |
| usr_we | input | 1 | User write request |
| usr_waddr | input | AW | User write address |
| usr_wdata | input | W | User write data |
| usr_re | input | 1 | User read request |
| usr_raddr | input | AW | User read address |
| usr_rdata | output | W | Read data returned to the user |
| ram_we | output | 1 | RAM write enable |
| ram_waddr | output | AW | RAM write address |
| ram_wdata | output | W | RAM write data |
| ram_re | output | 1 | RAM read enable |
| ram_raddr | output | AW | RAM read address |
| ram_rdata | input | W | RAM read data, one cycle after the read |
| test_fail | output | 1 | One-cycle pulse per failing address |

## Verification
A wrong address counter or pass-phase bit shows up at the RAM ports within one cycle. It appears as a read or write address off its ascending sequence, or as write data with the wrong polarity. A wrong phase also makes every read of the following pass mismatch, so `test_fail` is held high for almost that whole pass. A lost or misaligned write-address register shows up either as a collision between the two addresses in the same cycle, or as a word left unwritten. The unwritten word then fails on the next pass, about DEPTH cycles later. Errors injected into the RAM model check that the pulse arrives exactly two cycles after the read, and only once.

// File: rtl/dpst_pkg.sv
package dpst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_SCAN = 2'd2
  } dpst_state_t;

  // Alternating bits, odd positions set; sliced to the word width.
  localparam logic [63:0] ALT_ODD_BITS = 64'hAAAA_AAAA_AAAA_AAAA;

endpackage

// File: rtl/dpst_seq.sv
module dpst_seq
  import dpst_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 10,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic          active,
  output logic          t_we,
  output logic [AW-1:0] t_waddr,
  output logic [W-1:0]  t_wdata,
  output logic          t_re,
  output logic [AW-1:0] t_raddr,
  output logic          cmp_v,
  output logic [W-1:0]  cmp_exp
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LAST_ADDR = CW'(DEPTH - 1);
  localparam logic [CW-1:0] FLUSH_IDX = CW'(DEPTH);
  localparam logic [W-1:0]  BASE_PAT  = ALT_ODD_BITS[W-1:0];

  dpst_state_t   st_q;
  logic [CW-1:0] rp_q;   // read index within pass (DEPTH = flush slot)
  logic          pv_q;   // a read was issued last cycle
  logic [AW-1:0] pa_q;   // address of that read, written back this cycle
  logic          ph_q;   // 0: expect base pattern, 1: expect inverse

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      rp_q <= '0;
      pv_q <= 1'b0;
      pa_q <= '0;
      ph_q <= 1'b0;
    end else if (!en) begin
      st_q <= ST_IDLE;
      rp_q <= '0;
      pv_q <= 1'b0;
      ph_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_q <= ST_FILL;
          rp_q <= '0;
        end
        ST_FILL: begin
          if (rp_q == LAST_ADDR) begin
            st_q <= ST_SCAN;
            rp_q <= '0;
            ph_q <= 1'b0;
            pv_q <= 1'b0;
          end else begin
            rp_q <= rp_q + 1'b1;
          end
        end
        ST_SCAN: begin
          pv_q <= (rp_q != FLUSH_IDX);
          pa_q <= rp_q[AW-1:0];
          if (rp_q == FLUSH_IDX) begin
            rp_q <= '0;
            ph_q <= ~ph_q;
          end else begin
            rp_q <= rp_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    active  = (st_q != ST_IDLE);
    cmp_exp = ph_q ? ~BASE_PAT : BASE_PAT;
    t_re    = (st_q == ST_SCAN) && (rp_q != FLUSH_IDX);
    t_raddr = rp_q[AW-1:0];
    cmp_v   = (st_q == ST_SCAN) && pv_q;
    t_we    = 1'b0;
    t_waddr = pa_q;
    t_wdata = ~cmp_exp;
    if (st_q == ST_FILL) begin
      t_we    = 1'b1;
      t_waddr = rp_q[AW-1:0];
      t_wdata = BASE_PAT;
    end else if (st_q == ST_SCAN) begin
      t_we    = pv_q;
    end
  end

  // R4
  property p_sep;
    @(posedge clk) disable iff (!rst_n) (t_we && t_re) |-> (t_waddr != t_raddr);
  endproperty
  addr_sep_chk: assert property (p_sep);

  // R3
  property p_trail;
    @(posedge clk) disable iff (!rst_n)
      (t_re && en) |=> (t_we && (t_waddr == $past(t_raddr)));
  endproperty
  write_trails_read_chk: assert property (p_trail);

  // R6
  property p_phase;
    @(posedge clk) disable iff (!rst_n)
      (cmp_v && t_re && en) |=> (cmp_exp == $past(cmp_exp));
  endproperty
  phase_steady_chk: assert property (p_phase);

endmodule

// File: rtl/dpst_cmp.sv
module dpst_cmp #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         cmp_v,
  input  logic [W-1:0] cmp_exp,
  input  logic [W-1:0] rdata,
  output logic         fail
);

  logic fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fail_q <= 1'b0;
    else        fail_q <= active && cmp_v && (rdata != cmp_exp);
  end

  assign fail = fail_q;

  // R7
  property p_fail_src;
    @(posedge clk) disable iff (!rst_n) fail |-> $past(cmp_v);
  endproperty
  fail_has_cmp_chk: assert property (p_fail_src);

endmodule

// File: rtl/dpst_mux.sv
module dpst_mux #(
  parameter int AW = 4,
  parameter int W  = 10
) (
  input  logic          sel_test,
  input  logic          u_we,
  input  logic [AW-1:0] u_waddr,
  input  logic [W-1:0]  u_wdata,
  input  logic          u_re,
  input  logic [AW-1:0] u_raddr,
  input  logic          t_we,
  input  logic [AW-1:0] t_waddr,
  input  logic [W-1:0]  t_wdata,
  input  logic          t_re,
  input  logic [AW-1:0] t_raddr,
  output logic          m_we,
  output logic [AW-1:0] m_waddr,
  output logic [W-1:0]  m_wdata,
  output logic          m_re,
  output logic [AW-1:0] m_raddr
);

  always_comb begin
    if (sel_test) begin
      m_we    = t_we;
      m_waddr = t_waddr;
      m_wdata = t_wdata;
      m_re    = t_re;
      m_raddr = t_raddr;
    end else begin
      m_we    = u_we;
      m_waddr = u_waddr;
      m_wdata = u_wdata;
      m_re    = u_re;
      m_raddr = u_raddr;
    end
  end

endmodule

// File: rtl/dpram_selftest.sv
module dpram_selftest #(
  parameter int DEPTH = 16,
  parameter int W     = 10,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_en,
  input  logic          usr_we,
  input  logic [AW-1:0] usr_waddr,
  input  logic [W-1:0]  usr_wdata,
  input  logic          usr_re,
  input  logic [AW-1:0] usr_raddr,
  output logic [W-1:0]  usr_rdata,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [W-1:0]  ram_wdata,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr,
  input  logic [W-1:0]  ram_rdata,
  output logic          test_fail
);

  logic          active;
  logic          t_we, t_re, cmp_v;
  logic [AW-1:0] t_waddr, t_raddr;
  logic [W-1:0]  t_wdata, cmp_exp;

  dpst_seq #(.DEPTH(DEPTH), .W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(test_en), .active(active),
    .t_we(t_we), .t_waddr(t_waddr), .t_wdata(t_wdata),
    .t_re(t_re), .t_raddr(t_raddr), .cmp_v(cmp_v), .cmp_exp(cmp_exp)
  );

  dpst_cmp #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .active(active), .cmp_v(cmp_v),
    .cmp_exp(cmp_exp), .rdata(ram_rdata), .fail(test_fail)
  );

  dpst_mux #(.AW(AW), .W(W)) u_mux (
    .sel_test(active),
    .u_we(usr_we), .u_waddr(usr_waddr), .u_wdata(usr_wdata),
    .u_re(usr_re), .u_raddr(usr_raddr),
    .t_we(t_we), .t_waddr(t_waddr), .t_wdata(t_wdata),
    .t_re(t_re), .t_raddr(t_raddr),
    .m_we(ram_we), .m_waddr(ram_waddr), .m_wdata(ram_wdata),
    .m_re(ram_re), .m_raddr(ram_raddr)
  );

  assign usr_rdata = ram_rdata;

  // R7
  property p_fail_lat;
    @(posedge clk) disable iff (!rst_n) test_fail |-> $past(ram_re, 2);
  endproperty
  fail_latency_chk: assert property (p_fail_lat);

  // R2
  property p_fill_start;
    @(posedge clk) disable iff (!rst_n)
      $rose(active) |-> (ram_we && (ram_waddr == '0) && !ram_re);
  endproperty
  fill_start_chk: assert property (p_fill_start);

  // R1
  property p_idle_pass;
    @(posedge clk) disable iff (!rst_n)
      (!test_en && !$past(test_en)) |-> (ram_re == usr_re && ram_we == usr_we && !test_fail);
  endproperty
  idle_pass_chk: assert property (p_idle_pass);

endmodule

// File: tb/sim_dpram_selftest.sv
module sim_dpram_selftest;

  localparam int DEPTH = 16;
  localparam int W     = 10;
  localparam int AW    = 4;
  localparam logic [W-1:0] PA = 10'h2AA;
  localparam logic [W-1:0] PB = 10'h155;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_en = 1'b0;
  logic usr_we = 1'b0, usr_re = 1'b0;
  logic [AW-1:0] usr_waddr = '0, usr_raddr = '0;
  logic [W-1:0]  usr_wdata = '0;
  logic [W-1:0]  usr_rdata, ram_wdata, ram_rdata;
  logic ram_we, ram_re, test_fail;
  logic [AW-1:0] ram_waddr, ram_raddr;

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd_q = '0;
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (ram_we) mem[ram_waddr] <= ram_wdata;
    if (ram_re) rd_q <= mem[ram_raddr];
  end
  assign ram_rdata = rd_q;

  dpram_selftest #(.DEPTH(DEPTH), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .test_en(test_en),
    .usr_we(usr_we), .usr_waddr(usr_waddr), .usr_wdata(usr_wdata),
    .usr_re(usr_re), .usr_raddr(usr_raddr), .usr_rdata(usr_rdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .test_fail(test_fail)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check_user_path(input string req);
    chk(ram_we == usr_we && ram_re == usr_re, req, "enables", {ram_we, ram_re}, {usr_we, usr_re});
    chk(ram_waddr == usr_waddr && ram_raddr == usr_raddr, req, "addrs",
        {ram_waddr, ram_raddr}, {usr_waddr, usr_raddr});
    chk(ram_wdata == usr_wdata, req, "wdata", ram_wdata, usr_wdata);
    chk(usr_rdata == ram_rdata, req, "rdata", usr_rdata, ram_rdata);
    chk(test_fail == 1'b0, req, "fail idle", test_fail, 0);
  endtask

  // R1: reset and idle pass-through
  task automatic t_idle();
    rst_n = 0;
    step();
    rst_n = 1;
    step();
    usr_we = 1; usr_waddr = 4'd7; usr_wdata = 10'h3C1;
    usr_re = 1; usr_raddr = 4'd2;
    #1;
    check_user_path("R1");
    step();
    check_user_path("R1");
  endtask

  // R2, R8: fill pass, user inputs toggling
  task automatic t_fill();
    test_en = 1;
    for (int i = 0; i < DEPTH; i++) begin
      step();
      usr_we = ~usr_we; usr_waddr = AW'(i + 3); usr_re = 1; usr_raddr = AW'(i);
      #1;
      chk(ram_we == 1 && ram_re == 0, "R2", "fill enables", {ram_we, ram_re}, 2'b10);
      chk(ram_waddr == AW'(i), "R8", "fill waddr", ram_waddr, i);
      chk(ram_wdata == PA, "R2", "fill data", ram_wdata, PA);
    end
  endtask

  // R3 R4 R5 R6 R7 R10: one check pass; bad[] lists addresses expected to fail
  task automatic t_pass(input logic [W-1:0] exp, input bit [DEPTH-1:0] bad);
    for (int j = 0; j <= DEPTH; j++) begin
      step();
      chk(ram_re == (j < DEPTH), "R3", "read enable", ram_re, j < DEPTH);
      if (j < DEPTH) chk(ram_raddr == AW'(j), "R3", "read addr", ram_raddr, j);
      chk(ram_we == (j > 0), "R3", "write enable", ram_we, j > 0);
      if (j > 0) begin
        chk(ram_waddr == AW'(j - 1), "R3", "write addr", ram_waddr, j - 1);
        chk(ram_wdata == ~exp, "R5", "write data", ram_wdata, ~exp);
      end
      if (ram_we && ram_re)
        chk(ram_waddr != ram_raddr, "R4", "addr clash", ram_waddr, ram_raddr);
      begin
        bit want = (j >= 2) && bad[j - 2];
        chk(test_fail == want, "R7", "fail pulse", test_fail, want);
      end
    end
    for (int a = 0; a < DEPTH - 1; a++)
      chk(mem[a] == ~exp, "R5", "stored word", mem[a], ~exp);
  endtask

  task automatic t_clean_passes();
    t_pass(PA, '0);   // R6: first check expects base
    t_pass(PB, '0);   // R6: then inverse
  endtask

  // R7 R10 R5: injected upsets at 3 (three bits), 9 and 10 (one bit each)
  task automatic t_faults();
    mem[3]  = mem[3]  ^ 10'h0E0;
    mem[9]  = mem[9]  ^ 10'h001;
    mem[10] = mem[10] ^ 10'h200;
    t_pass(PA, 16'b0000_0110_0000_1000);
    t_pass(PB, '0);   // rewritten words are clean again
  endtask

  // R9: release and restart
  task automatic t_restart();
    for (int k = 0; k < 5; k++) step();
    test_en = 0;
    usr_we = 1; usr_waddr = 4'd11; usr_wdata = 10'h0F0; usr_re = 0; usr_raddr = 4'd1;
    step();
    check_user_path("R9");
    step();
    check_user_path("R9");
    test_en = 1;
    step();
    chk(ram_we && !ram_re && ram_waddr == 0 && ram_wdata == PA, "R9", "refill",
        {ram_we, ram_re, ram_waddr}, {2'b10, 4'd0});
  endtask

  initial begin
    t_idle();
    t_fill();
    t_clean_passes();
    t_faults();
    t_restart();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule